// File: doc/BRIEF.md
# ATM cell egress link-layer transmitter

This block sits between a user cell buffer and the 8-bit transmit port of a UTOPIA Level 1 PHY. The buffer holds each ATM cell as 27 words of 16 bits (a 54-byte cell). The block fetches the words one at a time through a read strobe and a word index. It splits each word into two bytes, upper byte first, and drives the bytes onto the PHY bus with an active-low enable and a start-of-cell flag on the first header byte. All logic runs on the transmit clock.

A mode input selects the cell length. In 54-byte mode every byte of the user cell is sent. In 53-byte mode the sixth byte (UDF2, the low byte of word 2) is discarded. The fetch schedule reads one word ahead of the bus. In 53-byte mode it issues two reads in a row, so the byte after the dropped one is ready in time. A cell that follows straight on from the previous one goes out with no idle cycle between them.

Top module: `utl_tx_link`

## Requirements
- R1: While rst_n is low at a clock edge, every register clears. After that edge phy_en_n=1, phy_soc=0, phy_byte=0 and usr_word_idx=0, and usr_rd is 0 while usr_avail is low.
- R2: From idle, usr_rd is high in a cycle exactly when usr_avail and phy_clav are both high. At the next edge phy_en_n goes low, phy_soc goes high and phy_byte carries bits 15:8 of that word (header byte 1).
- R3: Each usr_rd pulse makes the block capture usr_word at the next rising edge. usr_word_idx increments at that edge and after word 26 returns to 0. usr_word_idx never exceeds 26 and changes only after a read.
- R4: With mode_full=1 the cell is 54 bytes. The bytes are upper then lower byte of words 0 to 26, and phy_soc is high only on byte 0.
- R5: With mode_full=0 the cell is 53 bytes. Byte index 5 (bits 7:0 of word 2) is never sent, and byte index 6 follows byte index 4 directly.
- R6: Reads are separated by one idle cycle. The only exception is with mode_full=0, where the reads of word 2 and word 3 happen in consecutive cycles.
- R7: Once a cell has started, all of its bytes are sent on consecutive cycles, whatever usr_avail and phy_clav do.
- R8: If usr_avail and phy_clav are both high in the cycle that shows the final byte, usr_rd is high in that cycle, and the next cycle shows byte 0 of the next cell with phy_soc high.
- R9: If usr_avail or phy_clav is low in that final-byte cycle, phy_en_n goes high on the next edge. While phy_en_n is high, phy_soc=0, phy_byte=0, and usr_rd stays low until a start condition occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_full | input | 1 | 1: 54-byte cells, 0: 53-byte cells (UDF2 dropped); change only while idle |
| usr_avail | input | 1 | User buffer has a cell ready |
| usr_rd | output | 1 | Read strobe; the word is taken at the next rising edge |
| usr_word_idx | output | 5 | Index of the word being requested (0 to 26) |
| usr_word | input | 16 | Word from the buffer, bits 15:8 sent first |
| phy_clav | input | 1 | PHY can accept a cell |
| phy_en_n | output | 1 | Transmit enable to the PHY, active low |
| phy_soc | output | 1 | Start of cell, high with header byte 1 |
| phy_byte | output | 8 | Transmit data byte |

## Verification
The assertions watch several properties on every cycle. The enable only falls after a cycle in which both usr_avail and phy_clav were high. The start flag and the data stay quiet while the PHY is deselected. The word index stays in range and moves only after a read. The only consecutive reads are the word-2/word-3 pair in 53-byte mode. The UDF2 index is never presented, and a started cell never loses its enable before its final byte. Only the bench scenarios can show that the byte values follow the buffer contents in the right order. They also show that back-to-back cells abut without a gap, and that a cell runs to the end while usr_avail and phy_clav are withdrawn in the middle. These are swept over both cell lengths and all four combinations of the two ready inputs.

// File: rtl/utl_tx_pkg.sv
// Shared types for the egress link-layer transmitter.
// Assumes nothing beyond the standard SystemVerilog enum rules.
package utl_tx_pkg;

    // Sequencer state: whether a cell is on the PHY bus.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

endpackage

// File: rtl/utl_tx_seq.sv
// Cell sequencer: tracks which byte of the 54-byte user cell is on the bus.
// Decides whether the next cycle carries a byte, which byte that is, and
// whether a word must be fetched to supply it.
// Assumes DROP_IDX is odd (a low byte), so the byte after it starts a word,
// and that mode_full is stable while a cell is in flight.
module utl_tx_seq
    import utl_tx_pkg::*;
#(
    parameter int CELL_WORDS = 27,
    parameter int DROP_IDX   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_full,
    input  logic usr_avail,
    input  logic phy_clav,
    output logic go_o,
    output logic first_o,
    output logic rd_o
);
    localparam int CELL_BYTES = 2 * CELL_WORDS;
    localparam int IDX_W      = $clog2(CELL_BYTES);
    localparam int LAST_IDX   = CELL_BYTES - 1;

    tx_state_e        st_q;
    logic [IDX_W-1:0] k_q;
    logic [IDX_W-1:0] nk;
    logic             cont;
    logic             at_last;

    // Next-byte decision: start, continue, skip UDF2, or stop.
    always_comb begin
        cont    = usr_avail & phy_clav;
        at_last = (k_q == IDX_W'(LAST_IDX));
        go_o    = 1'b0;
        nk      = '0;
        if (st_q == ST_IDLE) begin
            go_o = cont;
        end else if (at_last) begin
            go_o = cont;
        end else begin
            go_o = 1'b1;
            if (!mode_full && (k_q == IDX_W'(DROP_IDX - 1))) begin
                nk = IDX_W'(DROP_IDX + 1);
            end else begin
                nk = k_q + 1'b1;
            end
        end
        rd_o    = go_o & ~nk[0];
        first_o = go_o & (nk == '0);
    end

    // State and byte-index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            k_q  <= '0;
        end else begin
            st_q <= go_o ? ST_SEND : ST_IDLE;
            k_q  <= nk;
        end
    end

    // R7: a started cell stays on the bus until its final byte.
    p_cell_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEND && !at_last) |=> (st_q == ST_SEND));

    // R5: in 53-byte mode the UDF2 index is never on the bus.
    p_udf_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEND && !mode_full) |-> (k_q != IDX_W'(DROP_IDX)));

    // R9: an idle sequencer is parked at byte 0.
    p_idle_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (k_q == '0));

endmodule

// File: rtl/utl_tx_fetch.sv
// Word fetch side: keeps the word index toward the user buffer and holds
// the low byte of the last fetched word until its turn on the bus.
// Assumes the buffer presents the requested word in the cycle the strobe
// is high.
module utl_tx_fetch #(
    parameter int CELL_WORDS = 27,
    parameter int BYTE_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_i,
    input  logic [2*BYTE_W-1:0]           word_i,
    output logic [$clog2(CELL_WORDS)-1:0] adr_o,
    output logic [BYTE_W-1:0]             lo_o
);
    localparam int ADR_W    = $clog2(CELL_WORDS);
    localparam int LAST_ADR = CELL_WORDS - 1;

    logic [ADR_W-1:0]  adr_q;
    logic [BYTE_W-1:0] lo_q;

    // Word index: advance on each capture, wrap after the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr_q <= '0;
        end else if (rd_i) begin
            adr_q <= (adr_q == ADR_W'(LAST_ADR)) ? '0 : adr_q + 1'b1;
        end
    end

    // Low-byte holding register, loaded with each captured word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (rd_i) begin
            lo_q <= word_i[BYTE_W-1:0];
        end
    end

    assign adr_o = adr_q;
    assign lo_o  = lo_q;

    // R3: the index stays within one cell.
    p_adr_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adr_q <= ADR_W'(LAST_ADR));

    // R3: the index moves only after a read.
    p_adr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_i) |-> $stable(adr_q));

endmodule

// File: rtl/utl_tx_drive.sv
// PHY output stage: registers enable, start-of-cell flag and data byte.
// An upper byte comes straight from the word being captured; a lower byte
// comes from the holding register. The bus is zero while deselected.
module utl_tx_drive #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              first_i,
    input  logic              rd_i,
    input  logic [BYTE_W-1:0] hi_i,
    input  logic [BYTE_W-1:0] lo_i,
    output logic              en_n_o,
    output logic              soc_o,
    output logic [BYTE_W-1:0] byte_o
);
    // Output registers toward the PHY.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_n_o <= 1'b1;
            soc_o  <= 1'b0;
            byte_o <= '0;
        end else begin
            en_n_o <= ~go_i;
            soc_o  <= first_i;
            byte_o <= !go_i ? '0 : (rd_i ? hi_i : lo_i);
        end
    end

endmodule

// File: rtl/utl_tx_link.sv
// Top of the egress link-layer transmitter: user cell buffer (16-bit words)
// to UTOPIA Level 1 transmit port (8-bit bytes), one clock domain.
// Assumes mode_full changes only while no cell is in flight and the buffer
// answers a read in the same cycle.
module utl_tx_link #(
    parameter int CELL_WORDS = 27,
    parameter int BYTE_W     = 8,
    parameter int DROP_IDX   = 5,
    localparam int ADR_W     = $clog2(CELL_WORDS),
    localparam int WORD_W    = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_full,
    input  logic              usr_avail,
    output logic              usr_rd,
    output logic [ADR_W-1:0]  usr_word_idx,
    input  logic [WORD_W-1:0] usr_word,
    input  logic              phy_clav,
    output logic              phy_en_n,
    output logic              phy_soc,
    output logic [BYTE_W-1:0] phy_byte
);
    localparam int PAIR_WORD = (DROP_IDX + 1) / 2;

    logic              go;
    logic              first;
    logic              rd;
    logic [BYTE_W-1:0] lo_byte;

    utl_tx_seq #(
        .CELL_WORDS(CELL_WORDS),
        .DROP_IDX  (DROP_IDX)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_full(mode_full),
        .usr_avail(usr_avail),
        .phy_clav (phy_clav),
        .go_o     (go),
        .first_o  (first),
        .rd_o     (rd)
    );

    utl_tx_fetch #(
        .CELL_WORDS(CELL_WORDS),
        .BYTE_W    (BYTE_W)
    ) u_fetch (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_i  (rd),
        .word_i(usr_word),
        .adr_o (usr_word_idx),
        .lo_o  (lo_byte)
    );

    utl_tx_drive #(
        .BYTE_W(BYTE_W)
    ) u_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go),
        .first_i(first),
        .rd_i   (rd),
        .hi_i   (usr_word[WORD_W-1:BYTE_W]),
        .lo_i   (lo_byte),
        .en_n_o (phy_en_n),
        .soc_o  (phy_soc),
        .byte_o (phy_byte)
    );

    assign usr_rd = rd;

    // R2: the PHY is only selected after both ready inputs were high.
    p_start_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_en_n) |-> $past(usr_avail && phy_clav));

    // R4: start of cell only appears while the PHY is selected.
    p_soc_framed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phy_soc |-> !phy_en_n);

    // R6: consecutive reads only fetch the word after UDF2 in 53-byte mode.
    p_rd_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_rd && $past(usr_rd)) |-> (!mode_full && usr_word_idx == ADR_W'(PAIR_WORD)));

    // R9: deselected bus is quiet.
    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phy_en_n |-> (!phy_soc && phy_byte == '0));

endmodule

// File: tb/utl_tx_link_bench.sv
`timescale 1ns/1ps
module utl_tx_link_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_full = 1'b1;
    logic       usr_avail = 1'b0;
    logic       phy_clav = 1'b0;
    logic       usr_rd;
    logic [4:0] usr_word_idx;
    logic [15:0] usr_word;
    logic       phy_en_n;
    logic       phy_soc;
    logic [7:0] phy_byte;

    int tests = 0;
    int fails = 0;
    int reads = 0;
    int exp_k = 0;
    int exp_cell = 0;
    int cells_seen = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    bit prev_last = 1'b0;
    bit prev_cont = 1'b0;
    bit cont_now;
    bit was_last;
    bit exp_rd;

    always #5 clk = ~clk;

    utl_tx_link u_utl_tx_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_full   (mode_full),
        .usr_avail   (usr_avail),
        .usr_rd      (usr_rd),
        .usr_word_idx(usr_word_idx),
        .usr_word    (usr_word),
        .phy_clav    (phy_clav),
        .phy_en_n    (phy_en_n),
        .phy_soc     (phy_soc),
        .phy_byte    (phy_byte)
    );

    function automatic logic [7:0] bval(input int c, input int k);
        return 8'((c * 61 + k * 3 + 5) & 255);
    endfunction

    // Buffer model: serves words in read order, 27 per cell.
    assign usr_word = {bval(reads / 27, 2 * (reads % 27)),
                       bval(reads / 27, 2 * (reads % 27) + 1)};

    always @(posedge clk) begin
        if (!rst_n) reads <= 0;
        else if (usr_rd) reads <= reads + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Cycle monitor: checks the bus, the strobe and the index every cycle.
    always @(negedge clk) begin
        if (mon_on) begin
            cont_now = usr_avail && phy_clav;
            chk(int'(usr_word_idx) == reads % 27, "R3 word index", usr_word_idx, reads % 27);
            if (prev_last) begin
                if (prev_cont) chk(!phy_en_n && phy_soc, "R8 back-to-back soc", phy_soc, 1);
                else chk(phy_en_n, "R9 deselect after last", phy_en_n, 1);
            end
            if (!phy_en_n) begin
                chk(phy_byte == bval(exp_cell, exp_k), mode_full ? "R4 byte" : "R5 byte",
                    phy_byte, bval(exp_cell, exp_k));
                chk(phy_soc == (exp_k == 0), "R2 soc position", phy_soc, exp_k == 0);
                if (exp_k == 0) cells_seen++;
                was_last = (exp_k == 53);
                if (was_last) begin
                    exp_k = 0;
                    exp_cell++;
                end else if (!mode_full && exp_k == 4) begin
                    exp_k = 6;
                end else begin
                    exp_k++;
                end
                exp_rd = was_last ? cont_now : (exp_k % 2 == 0);
                chk(usr_rd == exp_rd, was_last ? "R8 read at last byte" : "R6 read schedule",
                    usr_rd, exp_rd);
                prev_last = was_last;
                prev_cont = cont_now;
            end else begin
                chk(!phy_soc && phy_byte == 8'h00, "R9 quiet bus", phy_byte, 0);
                chk(exp_k == 0, "R7 cell cut short", exp_k, 0);
                chk(usr_rd == cont_now, "R2 start strobe", usr_rd, cont_now);
                prev_last = 1'b0;
                prev_cont = 1'b0;
            end
        end
    end

    task automatic drive(input bit av, input bit cl, input int cyc);
        @(posedge clk);
        #1;
        usr_avail = av;
        phy_clav  = cl;
        repeat (cyc) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(phy_en_n == 1'b1, "R1 enable", phy_en_n, 1);
        chk(phy_soc == 1'b0, "R1 soc", phy_soc, 0);
        chk(phy_byte == 8'h00, "R1 byte", phy_byte, 0);
        chk(usr_rd == 1'b0, "R1 read", usr_rd, 0);
        chk(usr_word_idx == 5'd0, "R1 index", usr_word_idx, 0);
        @(posedge clk);
        #1;
        rst_n  = 1'b1;
        mon_on = 1'b1;
        for (int m = 1; m >= 0; m--) begin
            int base;
            mode_full = m[0];
            // R2: one ready input alone never starts a cell
            base = cells_seen;
            drive(1'b0, 1'b1, 6);
            drive(1'b1, 1'b0, 6);
            chk(cells_seen == base, "R2 no start", cells_seen, base);
            // R7: single cell, ready inputs withdrawn right after the start
            base = cells_seen;
            drive(1'b1, 1'b1, 1);
            drive(1'b0, 1'b0, 70);
            chk(cells_seen == base + 1, "R7 single cell", cells_seen, base + 1);
            // R8: three back-to-back cells
            base = cells_seen;
            drive(1'b1, 1'b1, 3 * 54 - 10);
            drive(1'b0, 1'b0, 70);
            chk(cells_seen == base + 3, "R8 back-to-back count", cells_seen, base + 3);
            // Sweep of both ready inputs held over a cell's span
            for (int p = 0; p < 4; p++) begin
                drive(p[0], p[1], 40);
                drive(1'b0, 1'b0, 70);
            end
            chk(reads == exp_cell * 27, "R3 whole cells read", reads, exp_cell * 27);
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule